// File: doc/BRIEF.md
# SDRAM Low-Power State Sequencer

This block takes an SDRAM device into and out of its two low-power states: self refresh and precharge power-down. The requester holds `sleep_req` high with `sleep_mode` choosing the state. Once `banks_idle` reports that every bank is precharged, the sequencer takes over the clock-enable and command pins. For self refresh it can first issue a configurable burst of auto-refresh commands. It then drops CKE and stays asleep for as long as the request stays high.

Dropping `sleep_req` is the exit request. The sequencer raises CKE and holds NOP for the recovery window. That window is a full refresh cycle time after self refresh, or a short count after power-down. After self refresh it can issue a second refresh burst. Only then does `ready` return high and hand the pins back to normal traffic.

Deciding when to sleep and scheduling periodic refresh are left to the surrounding controller. That includes keeping a power-down short enough to respect the 64 ms refresh period.

Top module: `sdram_lp_ctrl`

## Requirements
- R1: During and right after reset, `ready` is 1, `asleep` is 0, `cke` is 1 and `cmd` is NOP. `cmd` is ordered {cs_n, ras_n, cas_n, we_n}, with NOP = 4'b0111.
- R2: A request is accepted only in a cycle where `ready`, `sleep_req` and `banks_idle` are all 1. While `banks_idle` is 0, `ready` stays 1 and the pins stay at CKE high with NOP.
- R3: On accepting a self-refresh request (`sleep_mode` = 1), with N_BURST > 0, the block first issues N_BURST refresh cycles with CKE high. Each refresh cycle is one cycle of REFRESH (4'b0001) followed by T_RFC cycles of NOP.
- R4: Self-refresh entry is a single cycle with `cke` = 0 and `cmd` = REFRESH. It is followed by the sleep state: `cke` = 0, `cmd` = NOP and `asleep` = 1.
- R5: Power-down entry (`sleep_mode` = 0) is a single cycle with `cke` = 0 and `cmd` = NOP, issued directly with no refresh burst. It is followed by the sleep state.
- R6: When `sleep_req` is low in the sleep state, the next cycle raises `cke` and holds NOP. This lasts T_RFC cycles after self refresh and T_PDX cycles after power-down.
- R7: After the self-refresh recovery window, the same refresh burst as in R3 is issued before control is returned.
- R8: `ready` stays 0 from acceptance until the whole exit sequence is finished, and only then returns to 1.
- R9: If `sleep_req` falls during the entry sequence, entry still completes. The sleep state is held for exactly one cycle, and then a normal exit follows.
- R10: Once a request is accepted, changes on `sleep_mode` and `banks_idle` have no effect. The mode captured at acceptance chooses the entry command and the recovery length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req | input | 1 | High to request a low-power state; low to request exit |
| sleep_mode | input | 1 | 1 = self refresh, 0 = precharge power-down |
| banks_idle | input | 1 | All banks are precharged and idle |
| cke | output | 1 | SDRAM clock enable |
| cmd | output | 4 | {cs_n, ras_n, cas_n, we_n} command pins |
| ready | output | 1 | Pins belong to normal traffic; exit complete |
| asleep | output | 1 | Device is in the low-power state |

## Verification
The bench builds the block with T_RFC = 4, N_BURST = 2 and T_PDX = 2. These values keep every refresh burst and recovery window a few cycles long, so full entry and exit sequences are compared cycle by cycle. Because the two recovery lengths differ, a recovery using the wrong captured mode shows up as a timing mismatch at `ready`. A second refresh in each burst exercises the burst counter's wrap from the pre-entry phase to the post-exit phase.

// File: rtl/sdram_lp_ctrl.sv
module sdram_lp_ctrl #(
  parameter int T_RFC   = 10,
  parameter int N_BURST = 1,
  parameter int T_PDX   = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sleep_req,
  input  logic       sleep_mode,
  input  logic       banks_idle,
  output logic       cke,
  output logic [3:0] cmd,
  output logic       ready,
  output logic       asleep
);
  localparam int MAXT = (T_RFC > T_PDX) ? T_RFC : T_PDX;
  localparam int CW   = (MAXT > 1) ? $clog2(MAXT) : 1;
  localparam int RW   = (N_BURST > 1) ? $clog2(N_BURST) : 1;
  localparam logic [3:0] NOP = 4'b0111;
  localparam logic [3:0] REF = 4'b0001;

  typedef enum logic [2:0] {S_RUN, S_AREF, S_ARW, S_ENT, S_SLP, S_WAKE} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [RW-1:0] nref;
  logic          sr_q, post_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_RUN;
      cnt    <= '0;
      nref   <= '0;
      sr_q   <= 1'b0;
      post_q <= 1'b0;
    end else begin
      case (st)
        S_RUN:
          if (sleep_req && banks_idle) begin
            sr_q   <= sleep_mode;
            post_q <= 1'b0;
            nref   <= '0;
            st     <= (sleep_mode && N_BURST > 0) ? S_AREF : S_ENT;
          end
        S_AREF: begin
          cnt <= CW'(T_RFC - 1);
          st  <= S_ARW;
        end
        S_ARW:
          if (cnt != '0)
            cnt <= cnt - 1'b1;
          else if (nref == RW'(N_BURST - 1))
            st <= post_q ? S_RUN : S_ENT;
          else begin
            nref <= nref + 1'b1;
            st   <= S_AREF;
          end
        S_ENT:
          st <= S_SLP;
        S_SLP:
          if (!sleep_req) begin
            cnt <= sr_q ? CW'(T_RFC - 1) : CW'(T_PDX - 1);
            st  <= S_WAKE;
          end
        S_WAKE:
          if (cnt != '0)
            cnt <= cnt - 1'b1;
          else if (sr_q && N_BURST > 0) begin
            post_q <= 1'b1;
            nref   <= '0;
            st     <= S_AREF;
          end else
            st <= S_RUN;
        default:
          st <= S_RUN;
      endcase
    end
  end

  assign cke    = !(st == S_ENT || st == S_SLP);
  assign cmd    = (st == S_AREF || (st == S_ENT && sr_q)) ? REF : NOP;
  assign ready  = (st == S_RUN);
  assign asleep = (st == S_SLP);
endmodule

// File: rtl/sdram_lp_ctrl_chk.sv
module sdram_lp_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sleep_req,
  input logic       banks_idle,
  input logic       cke,
  input logic [3:0] cmd,
  input logic       ready,
  input logic       asleep
);
  a_r4_sleep_cke_low: assert property (@(posedge clk) disable iff (!rst_n)
    asleep |-> (!cke && cmd == 4'b0111));

  a_r8_ready_pins_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (cke && cmd == 4'b0111 && !asleep));

  a_r2_accept_needs_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready) |-> $past(sleep_req && banks_idle));

  a_r6_wake_raises_cke: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(asleep) |-> (cke && cmd == 4'b0111 && !ready));

  a_r5_cke_fall_then_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke) |=> asleep);

  a_r9_exit_when_released: assert property (@(posedge clk) disable iff (!rst_n)
    (asleep && !sleep_req) |=> !asleep);
endmodule

bind sdram_lp_ctrl sdram_lp_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .banks_idle(banks_idle),
  .cke(cke), .cmd(cmd), .ready(ready), .asleep(asleep)
);

// File: tb/test_sdram_lp_ctrl.sv
module test_sdram_lp_ctrl;
  localparam int T_RFC = 4, N_BURST = 2, T_PDX = 2;
  localparam logic [3:0] NOP = 4'b0111, REF = 4'b0001;

  typedef struct packed {
    logic       cke;
    logic [3:0] cmd;
    logic       rdy;
    logic       slp;
  } exp_t;

  logic clk = 0, rst_n = 0;
  logic sleep_req = 0, sleep_mode = 0, banks_idle = 0;
  logic cke, ready, asleep;
  logic [3:0] cmd;
  int checks = 0, errors = 0;
  exp_t  q[$];
  string tq[$];
  exp_t  me;
  string mt;

  sdram_lp_ctrl #(.T_RFC(T_RFC), .N_BURST(N_BURST), .T_PDX(T_PDX)) i_sdram_lp_ctrl (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .sleep_mode(sleep_mode),
    .banks_idle(banks_idle), .cke(cke), .cmd(cmd), .ready(ready), .asleep(asleep));

  always #5 clk = ~clk;

  function automatic exp_t E(input logic k, input logic [3:0] c, input logic r, input logic s);
    E = '{cke: k, cmd: c, rdy: r, slp: s};
  endfunction

  task automatic compare(input exp_t e, input string tag);
    checks++;
    if (cke !== e.cke || cmd !== e.cmd || ready !== e.rdy || asleep !== e.slp) begin
      errors++;
      $display("FAIL %s: got cke=%b cmd=%b ready=%b asleep=%b, expected cke=%b cmd=%b ready=%b asleep=%b",
               tag, cke, cmd, ready, asleep, e.cke, e.cmd, e.rdy, e.slp);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      me = q.pop_front();
      mt = tq.pop_front();
      compare(me, mt);
    end
  end

  task automatic step(input logic r, input logic m, input logic idl, input exp_t e, input string tag);
    @(negedge clk);
    sleep_req = r; sleep_mode = m; banks_idle = idl;
    q.push_back(e);
    tq.push_back(tag);
  endtask

  task automatic burst(input logic r0, input logic r, input logic m0, input logic m, input string tag);
    for (int i = 0; i < N_BURST; i++) begin
      if (i == 0) step(r0, m0, 1, E(1, REF, 0, 0), tag);
      else        step(r, m, 1, E(1, REF, 0, 0), tag);
      for (int j = 0; j < T_RFC; j++) step(r, m, 1, E(1, NOP, 0, 0), tag);
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: got hung run, expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    compare(E(1, NOP, 1, 0), "R1 in reset");
    rst_n = 1;
    @(negedge clk);
    compare(E(1, NOP, 1, 0), "R1 after reset");

    // R2: request held off while banks busy
    for (int i = 0; i < 3; i++) step(1, 1, 0, E(1, NOP, 1, 0), "R2 busy banks");
    step(0, 1, 1, E(1, NOP, 1, 0), "R2 no request");

    // Self refresh full cycle: R3 R4 R6 R7 R8
    burst(1, 1, 1, 1, "R3 pre-entry refresh");
    step(1, 1, 1, E(0, REF, 0, 0), "R4 entry command");
    for (int i = 0; i < 3; i++) step(1, 1, 1, E(0, NOP, 0, 1), "R4 asleep");
    for (int i = 0; i < T_RFC; i++) step(0, 1, 1, E(1, NOP, 0, 0), "R6 sr recovery");
    burst(0, 0, 1, 1, "R7 post-exit refresh");
    step(0, 1, 1, E(1, NOP, 1, 0), "R8 ready after sr");

    // Power-down with mode and idle changes while asleep: R5 R10
    step(1, 0, 1, E(0, NOP, 0, 0), "R5 pd entry");
    step(1, 0, 1, E(0, NOP, 0, 1), "R5 pd asleep");
    step(1, 1, 0, E(0, NOP, 0, 1), "R10 inputs ignored asleep");
    for (int i = 0; i < T_PDX; i++) step(0, 1, 0, E(1, NOP, 0, 0), "R6 pd recovery");
    step(0, 1, 1, E(1, NOP, 1, 0), "R10 pd recovery length kept");

    // Request dropped during entry, mode flipped: R9 R10
    burst(1, 0, 1, 0, "R9 entry continues");
    step(0, 0, 0, E(0, REF, 0, 0), "R10 sr entry kept");
    step(0, 0, 1, E(0, NOP, 0, 1), "R9 one sleep cycle");
    for (int i = 0; i < T_RFC; i++) step(0, 0, 1, E(1, NOP, 0, 0), "R9 normal exit");
    burst(0, 0, 0, 0, "R7 post-exit refresh");
    step(0, 0, 1, E(1, NOP, 1, 0), "R8 ready after early exit");

    repeat (3) @(posedge clk);
    #5;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule